// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block stretches external bus cycles by a software-chosen number of data wait states. Eight external memory regions each carry their own 3-bit count, from 0 to 7 waits. The bus sequencer pulses a cycle-start strobe along with the region number and an access-type code. The block then holds its ready output low until the selected number of wait cycles has elapsed.

The count for each region is split across two configuration registers. A 16-bit word register holds the two low bits of every count, and an 8-bit register holds the top bit of every count. The word register accepts only full-width writes. The 8-bit register accepts plain byte writes and also single-bit set/clear writes. Internal memory and peripheral accesses never see programmed waits. DRAM and page-ROM on-page accesses also skip them, because their own controllers set their timing. Decoding addresses into regions is done upstream.

Top module: `wsg_top`

## Requirements
- R1: After reset the word register reads 0xFFFF and the high-bit register reads 0x00FF, so an external cycle to any region gets 7 waits.
- R2: Region n's count is {hi[n], lo[2n+1], lo[2n]}, taken as unsigned binary.
- R3: Address 0 (word register) is written only when reg_be_i is 2'b11. Any other byte-enable pattern leaves it unchanged.
- R4: Address 1 with reg_be_i[0] set and reg_bitop_i low loads hi from reg_wdata_i[7:0]. With reg_bitop_i high, only bit reg_wdata_i[2:0] changes, and it takes the value reg_wdata_i[3]. When reg_be_i[0] is clear, nothing is written.
- R5: reg_rdata_o returns the word register at address 0 and the zero-extended high-bit register at address 1.
- R6: For kind 0 (external, ordinary), rdy_o is low for exactly N data cycles after the start cycle and then rises in data cycle N. A count of 0 gives ready in the first data cycle.
- R7: Kinds 1 (internal memory or peripheral), 2 (DRAM) and 3 (page-ROM on-page) give ready in the first data cycle, whatever the programmed count.
- R8: A register write made while a cycle is in progress does not change that cycle's wait count.
- R9: A start strobe that arrives while a cycle is still waiting is ignored. A start strobe that arrives in the ready cycle begins a new cycle.
- R10: rdy_o is low when no cycle is in progress. With no new start, it stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = word register, 1 = high-bit register |
| reg_be_i | input | 2 | Byte enables |
| reg_bitop_i | input | 1 | Single-bit set/clear write to the high-bit register |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| cyc_start_i | input | 1 | Bus cycle start strobe |
| cyc_blk_i | input | 3 | Target region number |
| cyc_kind_i | input | 2 | Access type |
| rdy_o | output | 1 | Data ready to the bus sequencer |

## Verification
Several rules are checked on every cycle by the assertions. These cover the single-cycle ready pulse, ready staying low while idle, and the bypass kinds giving ready in the first data cycle. They also cover a zero or nonzero count producing or withholding ready in the first data cycle, and the rule that a pending cycle never ends early when a stray start arrives. Other behaviour only shows up in the bench scenarios. This includes the exact number of wait cycles for each region and count, the byte-enable and bit-operation write rules, and the reset values seen through readback. It also includes whether a count loaded at cycle start survives a register write made mid-cycle.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    KIND_EXT  = 2'd0,
    KIND_INT  = 2'd1,
    KIND_DRAM = 2'd2,
    KIND_PAGE = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/wsg_regs.sv
module wsg_regs #(
  parameter int NUM_BLK = 8,
  localparam int LO_W   = 2 * NUM_BLK,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [1:0]        be_i,
  input  logic              bitop_i,
  input  logic [LO_W-1:0]   wdata_i,
  output logic [LO_W-1:0]   lo_o,
  output logic [NUM_BLK-1:0] hi_o,
  output logic [LO_W-1:0]   rdata_o
);
  logic [LO_W-1:0]    lo_q;
  logic [NUM_BLK-1:0] hi_q;
  logic [BLK_W-1:0]   bit_idx;
  logic               bit_val;

  assign bit_idx = wdata_i[BLK_W-1:0];
  assign bit_val = wdata_i[BLK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '1;
      hi_q <= '1;
    end else if (wr_i) begin
      if (!addr_i) begin
        // word-only register
        if (be_i == 2'b11) lo_q <= wdata_i;
      end else if (be_i[0]) begin
        if (bitop_i) hi_q[bit_idx] <= bit_val;
        else         hi_q <= wdata_i[NUM_BLK-1:0];
      end
    end
  end

  assign lo_o    = lo_q;
  assign hi_o    = hi_q;
  assign rdata_o = addr_i ? {{(LO_W-NUM_BLK){1'b0}}, hi_q} : lo_q;
endmodule

// File: rtl/wsg_sel.sv
module wsg_sel
  import wsg_pkg::*;
#(
  parameter int NUM_BLK = 8,
  localparam int LO_W   = 2 * NUM_BLK,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic [LO_W-1:0]    lo_i,
  input  logic [NUM_BLK-1:0] hi_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  acc_kind_e          kind_i,
  output logic [CNT_W-1:0]   cnt_o
);
  logic [CNT_W-1:0] cnt_arr [NUM_BLK];

  for (genvar n = 0; n < NUM_BLK; n++) begin : g_blk
    assign cnt_arr[n] = {hi_i[n], lo_i[2*n+1], lo_i[2*n]};
  end

  // only plain external cycles use programmed waits
  assign cnt_o = (kind_i == KIND_EXT) ? cnt_arr[blk_i] : '0;
endmodule

// File: rtl/wsg_cnt.sv
module wsg_cnt
  import wsg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             busy_o,
  output logic             rdy_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rdy;
  logic             accept;

  assign rdy    = busy_q && (cnt_q == '0);
  assign accept = start_i && (!busy_q || rdy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= load_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign rdy_o  = rdy;
endmodule

// File: rtl/wsg_top.sv
module wsg_top
  import wsg_pkg::*;
#(
  parameter int NUM_BLK = 8,
  localparam int LO_W   = 2 * NUM_BLK,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic             reg_addr_i,
  input  logic [1:0]       reg_be_i,
  input  logic             reg_bitop_i,
  input  logic [LO_W-1:0]  reg_wdata_i,
  output logic [LO_W-1:0]  reg_rdata_o,
  input  logic             cyc_start_i,
  input  logic [BLK_W-1:0] cyc_blk_i,
  input  logic [1:0]       cyc_kind_i,
  output logic             rdy_o
);
  logic [LO_W-1:0]    lo_q;
  logic [NUM_BLK-1:0] hi_q;
  logic [CNT_W-1:0]   sel_cnt;
  logic               busy;
  acc_kind_e          kind;

  assign kind = acc_kind_e'(cyc_kind_i);

  wsg_regs #(.NUM_BLK(NUM_BLK)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .be_i    (reg_be_i),
    .bitop_i (reg_bitop_i),
    .wdata_i (reg_wdata_i),
    .lo_o    (lo_q),
    .hi_o    (hi_q),
    .rdata_o (reg_rdata_o)
  );

  wsg_sel #(.NUM_BLK(NUM_BLK)) u_sel (
    .lo_i   (lo_q),
    .hi_i   (hi_q),
    .blk_i  (cyc_blk_i),
    .kind_i (kind),
    .cnt_o  (sel_cnt)
  );

  wsg_cnt u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cyc_start_i),
    .load_i  (sel_cnt),
    .busy_o  (busy),
    .rdy_o   (rdy_o)
  );
endmodule

// File: rtl/wsg_chk.sv
module wsg_chk #(
  parameter int NUM_BLK = 8,
  localparam int LO_W   = 2 * NUM_BLK,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_start_i,
  input logic [BLK_W-1:0] cyc_blk_i,
  input logic [1:0]       cyc_kind_i,
  input logic             rdy_o,
  input logic             busy_i,
  input logic [LO_W-1:0]  lo_i,
  input logic [NUM_BLK-1:0] hi_i
);
  logic       taken;
  logic [2:0] prog_cnt;

  assign taken    = cyc_start_i && (!busy_i || rdy_o);
  assign prog_cnt = {hi_i[cyc_blk_i], lo_i[{cyc_blk_i, 1'b1}], lo_i[{cyc_blk_i, 1'b0}]};

  assert_idle_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !rdy_o);

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && !cyc_start_i) |=> !rdy_o);

  assert_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken && cyc_kind_i != 2'd0) |=> rdy_o);

  assert_zero_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken && cyc_kind_i == 2'd0 && prog_cnt == 3'd0) |=> rdy_o);

  assert_wait_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken && cyc_kind_i == 2'd0 && prog_cnt != 3'd0) |=> !rdy_o);

  assert_pending_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rdy_o) |=> busy_i);
endmodule

bind wsg_top wsg_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cyc_start_i (cyc_start_i),
  .cyc_blk_i   (cyc_blk_i),
  .cyc_kind_i  (cyc_kind_i),
  .rdy_o       (rdy_o),
  .busy_i      (busy),
  .lo_i        (lo_q),
  .hi_i        (hi_q)
);

// File: tb/sim_wsg_top.sv
module sim_wsg_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [1:0]  reg_be_i = 2'b00;
  logic        reg_bitop_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        cyc_start_i = 1'b0;
  logic [2:0]  cyc_blk_i = '0;
  logic [1:0]  cyc_kind_i = '0;
  logic        rdy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  wsg_top u0 (.*);

  // {blk, kind, expected waits}; config lo=E4E4 hi=F0 -> region n gets n waits
  localparam logic [7:0] VEC [12] = '{
    {3'd0, 2'd0, 3'd0}, {3'd1, 2'd0, 3'd1}, {3'd2, 2'd0, 3'd2}, {3'd3, 2'd0, 3'd3},
    {3'd4, 2'd0, 3'd4}, {3'd5, 2'd0, 3'd5}, {3'd6, 2'd0, 3'd6}, {3'd7, 2'd0, 3'd7},
    {3'd7, 2'd1, 3'd0}, {3'd5, 2'd2, 3'd0}, {3'd6, 2'd3, 3'd0}, {3'd3, 2'd0, 3'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [1:0] be, input logic bo, input logic [15:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_be_i = be; reg_bitop_i = bo; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_bitop_i = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic run_cycle(input logic [2:0] blk, input logic [1:0] kind, output int waits);
    @(negedge clk_i);
    cyc_start_i = 1'b1; cyc_blk_i = blk; cyc_kind_i = kind;
    @(negedge clk_i);
    cyc_start_i = 1'b0;
    waits = 0;
    while (!rdy_o && waits < 20) begin
      @(negedge clk_i);
      waits++;
    end
    @(negedge clk_i);
    check("R10 ready single cycle", rdy_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    int w;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // reset state
    reg_read(1'b0, rd); check("R1 lo reset", rd, 16'hFFFF);
    reg_read(1'b1, rd); check("R1 hi reset", rd, 16'h00FF);
    check("R10 idle ready low", rdy_o, 1'b0);
    run_cycle(3'd3, 2'd0, w); check("R1 reset waits", w, 7);

    // configure
    reg_write(1'b0, 2'b11, 1'b0, 16'hE4E4);
    reg_write(1'b1, 2'b01, 1'b0, 16'h00F0);
    reg_read(1'b0, rd); check("R5 lo readback", rd, 16'hE4E4);
    reg_read(1'b1, rd); check("R4 hi byte write", rd, 16'h00F0);

    // vector table
    foreach (VEC[i]) begin
      run_cycle(VEC[i][7:5], VEC[i][4:3], w);
      if (VEC[i][4:3] == 2'd0) check("R2 R6 waits per region", w, VEC[i][2:0]);
      else                     check("R7 bypass kind", w, VEC[i][2:0]);
    end

    // R3: partial writes to the word register are dropped
    reg_write(1'b0, 2'b01, 1'b0, 16'h0000);
    reg_write(1'b0, 2'b10, 1'b0, 16'h0000);
    reg_read(1'b0, rd); check("R3 partial write ignored", rd, 16'hE4E4);
    run_cycle(3'd2, 2'd0, w); check("R3 region2 unchanged", w, 2);

    // R4: no byte enable -> no write
    reg_write(1'b1, 2'b00, 1'b0, 16'h0000);
    reg_read(1'b1, rd); check("R4 hi no enable", rd, 16'h00F0);

    // R4: bit operations
    reg_write(1'b1, 2'b01, 1'b1, 16'h0007);  // clear bit 7
    reg_read(1'b1, rd); check("R4 bit clear", rd, 16'h0070);
    run_cycle(3'd7, 2'd0, w); check("R4 region7 after clear", w, 3);
    reg_write(1'b1, 2'b01, 1'b1, 16'h0009);  // set bit 1
    reg_read(1'b1, rd); check("R4 bit set", rd, 16'h0072);
    run_cycle(3'd1, 2'd0, w); check("R4 region1 after set", w, 5);

    // R8: mid-cycle write does not alter loaded count (region2 = 2 waits)
    @(negedge clk_i);
    cyc_start_i = 1'b1; cyc_blk_i = 3'd2; cyc_kind_i = 2'd0;
    @(negedge clk_i);
    cyc_start_i = 1'b0;
    reg_wr_i = 1'b1; reg_addr_i = 1'b0; reg_be_i = 2'b11; reg_wdata_i = 16'h0000;
    check("R8 wait cycle 0", rdy_o, 1'b0);
    @(negedge clk_i);
    reg_wr_i = 1'b0;
    check("R8 wait cycle 1", rdy_o, 1'b0);
    @(negedge clk_i);
    check("R8 ready after 2", rdy_o, 1'b1);
    @(negedge clk_i);
    reg_write(1'b0, 2'b11, 1'b0, 16'hE4E4);
    reg_write(1'b1, 2'b01, 1'b0, 16'h00F0);

    // R9: start during wait is ignored (region7 = 7, region0 = 0)
    @(negedge clk_i);
    cyc_start_i = 1'b1; cyc_blk_i = 3'd7; cyc_kind_i = 2'd0;
    @(negedge clk_i);
    cyc_blk_i = 3'd0;
    w = 0;
    while (!rdy_o && w < 20) begin
      @(negedge clk_i);
      if (w == 0) cyc_start_i = 1'b0;
      w++;
    end
    check("R9 start ignored while waiting", w, 7);
    @(negedge clk_i);
    check("R10 idle after cycle", rdy_o, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule